// File: doc/BRIEF.md
# Serial Memory Write-Protection Unit

This block owns the status byte of a small serial memory and decides, request by request, whether a write may proceed. It keeps a write-enable latch, a two-bit block-protect field and a protect-enable bit. It also samples an active-low hardware protect pin. A front end that has already shifted and decoded the serial traffic presents command strobes and array write requests. The block answers each one with grant signals in the same cycle. The memory array and the serial shifter sit outside it.

The array write request is a one-way stream with no back-pressure. A request is consumed in every cycle in which `aw_valid` is high. `aw_grant` in that same cycle says whether the byte may be committed, and no request ever waits. Status writes behave the same way: a strobe is either granted or dropped in its own cycle. All strobes count only while chip select (`cs_n`, active low) is low.

The block-protect field and the protect-enable bit stand in for non-volatile cells. The ordinary reset leaves them untouched, and only the separate `por_init` input loads them with zero.

Top module: `wpu_top`

## Requirements
- R1: Status bits 6 reads 1; bits 5, 4 and 0 read 0 at all times, whatever is written.
- R2: The enable strobe sets the write-enable latch and the disable strobe clears it (disable wins if both arrive together); a granted status write leaves the latch unchanged in its cycle.
- R3: Block-protect value 0 protects no address, 1 protects addresses whose two top bits are 11 (C000h–FFFFh), 2 protects addresses whose top bit is 1 (8000h–FFFFh), 3 protects every address; a write to a protected address is never granted.
- R4: While the write-enable latch is 0, neither `aw_grant` nor `sr_grant` is ever high.
- R5: When the protect-enable bit is 1 and the captured pin value is 0, a status write is refused; when the protect-enable bit is 0 the pin has no effect on status writes.
- R6: When chip select rises after at least one granted array or status write in that transaction, the latch is 0 from the next cycle on; reset also clears the latch.
- R7: The protect pin is captured in the cycle chip select falls (that cycle already uses the new value); changes of the pin later in the transaction have no effect until the next falling edge.
- R8: The ordinary reset leaves block-protect and protect-enable unchanged; `por_init` loads both with 0 and takes precedence over a status write.
- R9: Strobes and array requests presented while `cs_n` is high have no effect and are never granted.
- R10: A read strobe loads `status_o` on the next edge with {protect-enable at bit 7, 1, 0, 0, block-protect at bits 3:2, latch at bit 1, 0}; `status_o` holds between reads and is 40h after reset.
- R11: A granted status write loads protect-enable from data bit 7 and block-protect from data bits 3:2; the other data bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the volatile state |
| por_init | input | 1 | Power-on load: clears block-protect and protect-enable |
| cs_n | input | 1 | Chip select from the serial front end, active low |
| wp_n | input | 1 | Hardware protect pin, active low |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Byte offered with the status write |
| cmd_rdsr | input | 1 | Status read strobe |
| aw_valid | input | 1 | Array write request |
| aw_addr | input | 16 | Array write address |
| aw_grant | output | 1 | Array write allowed this cycle |
| sr_grant | output | 1 | Status write allowed this cycle |
| status_o | output | 8 | Status byte snapshot |

## Verification
The hardest case to reach is a hardware lock under a changing pin. Protect-enable must already be 1 from an earlier granted status write. The pin must be low exactly at the falling edge of chip select and then go high inside the transaction, and a new enable and status write must follow before chip select rises. Directed transactions set up that sequence. Random transactions then mix pin toggles at arbitrary cycles within a transaction, strobes with chip select high, and occasional power-on loads. Each transaction runs against a bench model of the latch, the captured pin and the protection fields.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int STAT_W    = 8;
  localparam int POS_PEN   = 7;
  localparam int POS_ONE   = 6;
  localparam int POS_BPH   = 3;
  localparam int POS_BPL   = 2;
  localparam int POS_LATCH = 1;
  localparam logic [STAT_W-1:0] STAT_FIXED = 8'h40;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'd0,
    PROT_QUARTER = 2'd1,
    PROT_HALF    = 2'd2,
    PROT_ALL     = 2'd3
  } prot_t;

  // top2 carries the two most significant address bits
  function automatic logic region_hit(input prot_t sel, input logic [1:0] top2);
    case (sel)
      PROT_NONE:    region_hit = 1'b0;
      PROT_QUARTER: region_hit = (top2 == 2'b11);
      PROT_HALF:    region_hit = top2[1];
      default:      region_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/wpu_cs_track.sv
module wpu_cs_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wp_n,
  output logic active,
  output logic cs_fall,
  output logic cs_rise,
  output logic wp_lat,
  output logic wp_eff
);
  logic cs_q;

  assign active  = ~cs_n;
  assign cs_fall = ~cs_n & cs_q;
  assign cs_rise = cs_n & ~cs_q;
  // the edge cycle itself already sees the freshly sampled pin
  assign wp_eff  = cs_fall ? wp_n : wp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      wp_lat <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (cs_fall) wp_lat <= wp_n;
    end
  end
endmodule

// File: rtl/wpu_latch.sv
module wpu_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wrote_i,
  input  logic cs_rise,
  output logic wel,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      done <= 1'b0;
    end else begin
      if (cs_rise)      done <= 1'b0;
      else if (wrote_i) done <= 1'b1;

      if (clr_i)                wel <= 1'b0;
      else if (set_i)           wel <= 1'b1;
      else if (cs_rise && done) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/wpu_nv_regs.sv
module wpu_nv_regs
  import wpu_pkg::*;
(
  input  logic              clk,
  input  logic              por_init,
  input  logic              load_i,
  input  logic [STAT_W-1:0] data_i,
  output prot_t             bp,
  output logic              wpen
);
  logic unused_data;
  assign unused_data = ^{data_i[6:4], data_i[1:0]};

  // no reset on purpose: these model retained cells
  always_ff @(posedge clk) begin
    if (por_init) begin
      bp   <= PROT_NONE;
      wpen <= 1'b0;
    end else if (load_i) begin
      bp   <= prot_t'(data_i[POS_BPH:POS_BPL]);
      wpen <= data_i[POS_PEN];
    end
  end
endmodule

// File: rtl/wpu_gate.sv
module wpu_gate
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              active,
  input  logic              wel,
  input  logic              wpen,
  input  logic              wp_eff,
  input  prot_t             bp,
  input  logic              aw_valid,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              wrsr,
  output logic              aw_ok,
  output logic              sr_ok
);
  localparam int TOP = ADDR_W - 1;
  logic hit;
  logic hw_lock;
  logic unused_low;

  assign unused_low = ^aw_addr[TOP-2:0];
  assign hit     = region_hit(bp, aw_addr[TOP -: 2]);
  assign hw_lock = wpen & ~wp_eff;
  assign aw_ok   = active & aw_valid & wel & ~hit;
  assign sr_ok   = active & wrsr & wel & ~hw_lock;
endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_init,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              cmd_rdsr,
  input  logic              aw_valid,
  input  logic [ADDR_W-1:0] aw_addr,
  output logic              aw_grant,
  output logic              sr_grant,
  output logic [STAT_W-1:0] status_o
);
  logic  active, cs_fall, cs_rise, wp_lat, wp_eff;
  logic  wel, done, wpen;
  prot_t bp;
  logic [STAT_W-1:0] stat_now;

  wpu_cs_track u_cs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .active(active), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .wp_lat(wp_lat), .wp_eff(wp_eff)
  );

  wpu_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .set_i(active & cmd_wren), .clr_i(active & cmd_wrdi),
    .wrote_i(aw_grant | sr_grant), .cs_rise(cs_rise),
    .wel(wel), .done(done)
  );

  wpu_nv_regs u_nv (
    .clk(clk), .por_init(por_init), .load_i(sr_grant),
    .data_i(wrsr_data), .bp(bp), .wpen(wpen)
  );

  wpu_gate #(.ADDR_W(ADDR_W)) u_gate (
    .active(active), .wel(wel), .wpen(wpen), .wp_eff(wp_eff), .bp(bp),
    .aw_valid(aw_valid), .aw_addr(aw_addr), .wrsr(cmd_wrsr),
    .aw_ok(aw_grant), .sr_ok(sr_grant)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == POS_PEN) begin : g_pen
      assign stat_now[b] = wpen;
    end else if (b == POS_BPH || b == POS_BPL) begin : g_bp
      assign stat_now[b] = bp[b-POS_BPL];
    end else if (b == POS_LATCH) begin : g_wel
      assign stat_now[b] = wel;
    end else begin : g_fix
      assign stat_now[b] = STAT_FIXED[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   status_o <= STAT_FIXED;
    else if (active && cmd_rdsr)  status_o <= stat_now;
  end
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       aw_grant,
  input logic       sr_grant,
  input logic [7:0] status_o,
  input logic       wel,
  input logic       done,
  input logic       wpen,
  input logic [1:0] bp,
  input logic       wp_lat,
  input logic       wp_eff,
  input logic       cs_fall,
  input logic       cs_rise
);
  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] && (status_o[5:4] == 2'b00) && !status_o[0]);
  p_wrsr_keeps_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant && !cmd_wren && !cmd_wrdi) |=> wel);
  p_full_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 2'b11) |-> !aw_grant);
  p_grant_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_grant || sr_grant) |-> wel);
  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_eff) |-> !sr_grant);
  p_latch_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && done) |=> !wel);
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(wp_lat));
endmodule

bind wpu_top wpu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .aw_grant(aw_grant), .sr_grant(sr_grant), .status_o(status_o),
  .wel(wel), .done(done), .wpen(wpen), .bp(bp), .wp_lat(wp_lat),
  .wp_eff(wp_eff), .cs_fall(cs_fall), .cs_rise(cs_rise)
);

// File: tb/wpu_top_test.sv
module wpu_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_init = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
  logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_rdsr = 1'b0, aw_valid = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic [15:0] aw_addr = 16'h0000;
  logic aw_grant, sr_grant;
  logic [7:0] status_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench model
  logic m_wel, m_done, m_csq, m_wplat, m_wpen;
  logic [1:0] m_bp;
  logic [7:0] m_stat;

  always #2 clk = ~clk;

  wpu_top uut (
    .clk(clk), .rst_n(rst_n), .por_init(por_init), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .cmd_rdsr(cmd_rdsr), .aw_valid(aw_valid),
    .aw_addr(aw_addr), .aw_grant(aw_grant), .sr_grant(sr_grant), .status_o(status_o)
  );

  function automatic logic hit_f(input logic [1:0] bp, input logic [15:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a[15:14] == 2'b11;
      2'd2: return a[15];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] stat_f(input logic pen, input logic [1:0] bp, input logic w);
    return {pen, 1'b1, 2'b00, bp, w, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wel = 0; m_done = 0; m_csq = 1; m_wplat = 1; m_stat = 8'h40;
  endtask

  // op: 0 idle, 1 enable, 2 disable, 3 status write, 4 status read, 5 array write
  task automatic cyc(input logic c, input logic w, input int op, input logic [7:0] d,
                     input logic [15:0] a, input logic p, input string tag);
    logic fall, rise, act, wpe, e_sr, e_aw;
    logic n_wel, n_done, n_pen; logic [1:0] n_bp; logic [7:0] n_stat;
    @(negedge clk);
    cs_n = c; wp_n = w; por_init = p; wrsr_data = d; aw_addr = a;
    cmd_wren = (op == 1); cmd_wrdi = (op == 2); cmd_wrsr = (op == 3);
    cmd_rdsr = (op == 4); aw_valid = (op == 5);
    #1;
    fall = !c && m_csq; rise = c && !m_csq; act = !c;
    wpe  = fall ? w : m_wplat;
    e_sr = act && (op == 3) && m_wel && !(m_wpen && !wpe);
    e_aw = act && (op == 5) && m_wel && !hit_f(m_bp, a);
    check({tag, " R4 array grant"}, 16'(aw_grant), 16'(e_aw));
    check({tag, " R5 status grant"}, 16'(sr_grant), 16'(e_sr));
    n_wel = m_wel;
    if (act && op == 2) n_wel = 0;
    else if (act && op == 1) n_wel = 1;
    else if (rise && m_done) n_wel = 0;
    n_done = rise ? 1'b0 : (m_done || e_sr || e_aw);
    n_pen = m_wpen; n_bp = m_bp;
    if (p) begin n_pen = 0; n_bp = 0; end
    else if (e_sr) begin n_pen = d[7]; n_bp = d[3:2]; end
    n_stat = (act && op == 4) ? stat_f(m_wpen, m_bp, m_wel) : m_stat;
    @(posedge clk); #1;
    m_wel = n_wel; m_done = n_done; m_wpen = n_pen; m_bp = n_bp; m_stat = n_stat;
    if (fall) m_wplat = w;
    m_csq = c;
    check({tag, " R10 status byte"}, 16'(status_o), 16'(m_stat));
  endtask

  task automatic rd(input string tag);
    cyc(1'b0, wp_n, 4, 8'h00, 16'h0, 1'b0, tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    // power-on load while in reset
    por_init = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    m_wpen = 0; m_bp = 0;
    por_init = 1'b0;
    rst_n = 1'b1;
    check("R10 reset value", 16'(status_o), 16'h40);
    check("R1 fixed bits after reset", 16'(status_o & 8'h71), 16'h40);

    // R4: no latch, no grants
    cyc(0, 1, 5, 8'h00, 16'h1234, 0, "R4 aw without latch");
    cyc(0, 1, 3, 8'hFF, 16'h0, 0, "R4 wrsr without latch");
    cyc(0, 1, 1, 8'h00, 16'h0, 0, "R2 enable");
    rd("R2 read");
    check("R2 latch set", 16'(status_o), 16'h42);
    cyc(0, 1, 3, 8'hFF, 16'h0, 0, "R11 wrsr all ones");
    rd("R11 read");
    check("R11 R1 R2 status after write", 16'(status_o), 16'hCE);
    cyc(0, 1, 5, 8'h00, 16'h0000, 0, "R3 full lock");
    check("R3 address 0 refused", 16'(aw_grant), 16'h0);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "R6 cs rise");
    rd("R6 read");
    check("R6 latch dropped", 16'(status_o), 16'hCC);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "idle");
    // R5/R7: pin low at fall, raised mid transaction
    cyc(0, 0, 1, 8'h00, 16'h0, 0, "R7 fall pin low");
    cyc(0, 0, 3, 8'h00, 16'h0, 0, "R5 locked wrsr");
    cyc(0, 1, 3, 8'h00, 16'h0, 0, "R7 pin raised mid");
    check("R7 still locked", 16'(sr_grant), 16'h0);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "R6 rise no write");
    cyc(0, 1, 3, 8'h04, 16'h0, 0, "R7 new fall pin high");
    check("R7 unlocked by new capture", 16'(sr_grant), 16'h1);
    cyc(0, 1, 5, 8'h00, 16'hBFFF, 0, "R3 quarter below");
    check("R3 BFFF granted", 16'(aw_grant), 16'h1);
    cyc(0, 1, 5, 8'h00, 16'hC000, 0, "R3 quarter start");
    check("R3 C000 refused", 16'(aw_grant), 16'h0);
    cyc(0, 0, 3, 8'h08, 16'h0, 0, "R5 wpen 0 ignores pin");
    check("R5 pin ignored", 16'(sr_grant), 16'h1);
    cyc(0, 1, 5, 8'h00, 16'h8000, 0, "R3 half start");
    check("R3 8000 refused", 16'(aw_grant), 16'h0);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "R6 rise");
    // R9: strobes with cs high
    cyc(1, 1, 1, 8'h00, 16'h0, 0, "R9 enable while idle");
    cyc(1, 1, 3, 8'hFF, 16'h0, 0, "R9 wrsr while idle");
    cyc(1, 1, 4, 8'h00, 16'h0, 0, "R9 read while idle");
    rd("R9 read");
    check("R9 idle strobes ignored", 16'(status_o), 16'h48);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "idle");
    // R8: reset keeps retained fields
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model_reset();
    rd("R8 read after reset");
    check("R8 bp kept over reset", 16'(status_o), 16'h48);
    cyc(0, 1, 1, 8'h00, 16'h0, 1, "R8 por with enable");
    cyc(0, 1, 3, 8'hFF, 16'h0, 1, "R8 por beats wrsr");
    rd("R8 read");
    check("R8 por cleared fields", 16'(status_o), 16'h42);
    cyc(1, 1, 0, 8'h00, 16'h0, 0, "R6 rise");

    // random transactions
    for (int t = 0; t < 600; t++) begin
      int len;
      len = 1 + int'($urandom % 5);
      for (int k = 0; k < len; k++) begin
        logic w; int op;
        w  = ($urandom % 4) != 0;
        op = int'($urandom % 6);
        cyc(0, w, op, 8'($urandom), 16'($urandom), ($urandom % 60) == 0, "rand R2 R6 R11");
      end
      cyc(1, ($urandom % 2) == 1, int'($urandom % 6), 8'($urandom), 16'($urandom),
          1'b0, "rand R9 R7");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule